// File: doc/BRIEF.md
# Isochronous Transmit DMA Scheduler

This block feeds a transmit FIFO with isochronous payload fetched from host memory, once per bus isochronous cycle. Four transmit contexts sit side by side. Each has its own enable and its own descriptor pointer, and each context corresponds to one isochronous channel. A cycle-start pulse launches a walk over the contexts in ascending index order. An enabled context costs two host-bus accesses. The first reads a two-word descriptor at the context's pointer. The second reads the payload that the descriptor points to. Each payload word goes into the FIFO tagged with the context index. A disabled context is passed over without touching the bus.

After the last context the scheduler writes a flagged marker word. This tells the FIFO reader that nothing more will come for this cycle. The host bus is a request/grant pair plus a burst-read port: a one-cycle command with address and word count, then data beats under a valid/ready handshake. A full FIFO stalls payload beats and the marker. A cycle start that arrives while a walk is still running is remembered, and the next walk starts straight after the marker.

Top module: `itx_sched`

## Requirements
- R1: While `rst_n` is low, `bus_req_o`, `rd_cmd_o` and `fifo_push_o` are low, and after reset the block stays idle until `cyc_start_i` pulses.
- R2: A walk visits contexts 0,1,2,3 in that order. All FIFO words of context i precede those of context i+1, and every payload word carries its context index on `fifo_ctx_o`.
- R3: A context whose `ctx_active_i` bit is low when the walk reaches it produces no bus request, no read command and no FIFO word.
- R4: `bus_req_o` stays high until `bus_gnt_i` is seen. `rd_cmd_o` pulses for exactly one cycle, only in the cycle after a grant was sampled with the request high, and only while the request is held.
- R5: For an active context the first read is a 2-word burst at that context's pointer. Word 0 bits [15:0] give the payload byte count, and the other bits of word 0 are ignored. Word 1 gives the payload byte address.
- R6: The second read is a burst at the payload address of ceil(bytes/4) words. Every accepted beat is pushed to the FIFO in order with `fifo_mark_o` = 0. A byte count of 0 issues no second read.
- R7: Every walk ends with exactly one push of data 32'hFFFF_0000 with `fifo_mark_o` = 1, also when no context is active.
- R8: No push happens in a cycle where `fifo_full_i` is high. Payload beats are not accepted (`rd_dready_o` low) and the marker waits while the FIFO is full, and no word is lost or repeated.
- R9: One or more `cyc_start_i` pulses during a walk cause exactly one further walk. It begins right after the current marker without another pulse.
- R10: A write with `cfg_wr_i` high stores `cfg_ptr_i` as the descriptor pointer of context `cfg_idx_i`, and the next walk fetches that context's descriptor from the new pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start_i | input | 1 | Isochronous cycle-start pulse |
| ctx_active_i | input | NUM_CTX | Per-context enable |
| cfg_wr_i | input | 1 | Descriptor pointer write strobe |
| cfg_idx_i | input | CTX_W | Context selected by the pointer write |
| cfg_ptr_i | input | ADDR_W | Descriptor pointer value |
| bus_req_o | output | 1 | Host bus request |
| bus_gnt_i | input | 1 | Host bus grant |
| rd_cmd_o | output | 1 | Burst read command strobe |
| rd_addr_o | output | ADDR_W | Burst start byte address |
| rd_len_o | output | LEN_W | Burst length in 32-bit words |
| rd_dvalid_i | input | 1 | Read data beat valid |
| rd_data_i | input | DATA_W | Read data beat |
| rd_dready_o | output | 1 | Read data beat accepted |
| fifo_push_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | DATA_W | FIFO write data |
| fifo_mark_o | output | 1 | Flag bit: word is the end-of-cycle marker |
| fifo_ctx_o | output | CTX_W | Context index of a payload word |
| fifo_full_i | input | 1 | FIFO full |

## Verification
Several enable patterns are tried: all contexts on, alternating contexts, and none. Comparing them shows that the walk order is correct and that disabled contexts are really skipped. The all-off walk also isolates the marker path. Zero-length and non-multiple-of-four byte counts separate the word rounding from the no-payload path. Grant delays and gaps between data beats test the request/grant protocol and the beat counting. A randomly toggling FIFO full shows that a stall holds data back rather than dropping or repeating it. Bursts of start pulses in the middle of a walk check that they merge into one follow-on walk. Rewriting a pointer between walks shows that descriptors follow the register.

// File: rtl/itx_pkg.sv
package itx_pkg;

  // walk-level state of the scheduler
  typedef enum logic [2:0] {
    W_IDLE,
    W_SCAN,
    W_DESC,
    W_DEC,
    W_PAY,
    W_MARK
  } walk_st_t;

  // state of one host-bus burst access
  typedef enum logic [1:0] {
    E_IDLE,
    E_REQ,
    E_CMD,
    E_DATA
  } eng_st_t;

  // end-of-cycle word, paired with the flag bit on the FIFO side
  localparam logic [31:0] CYC_MARKER = 32'hFFFF_0000;

  // descriptor size in words
  localparam int DESC_WORDS = 2;

endpackage

// File: rtl/itx_ptr_bank.sv
module itx_ptr_bank #(
  parameter int NUM_CTX = 4,
  parameter int ADDR_W  = 32,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_i,
  input  logic [CTX_W-1:0]               idx_i,
  input  logic [ADDR_W-1:0]              data_i,
  output logic [NUM_CTX-1:0][ADDR_W-1:0] ptr_o
);

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ptr
    logic              wr_en;
    logic [ADDR_W-1:0] ptr_q;

    assign wr_en = wr_i && (idx_i == CTX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q <= '0;
      end else if (wr_en) begin
        ptr_q <= data_i;
      end
    end

    assign ptr_o[g] = ptr_q;
  end

endmodule

// File: rtl/itx_start_pend.sv
module itx_start_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  input  logic consume_i,
  output logic pend_o
);

  logic pend_q, pend_d;

  always_comb begin
    pend_d = (pend_q || (start_i && busy_i)) && !consume_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/itx_burst_fetch.sv
module itx_burst_fetch
  import itx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  nwords_i,
  input  logic              sink_rdy_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              rd_cmd_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [CNT_W-1:0]  rd_len_o,
  input  logic              rd_dvalid_i,
  output logic              rd_dready_o,
  output logic              beat_o,
  output logic [CNT_W-1:0]  beat_idx_o,
  output logic              done_o
);

  eng_st_t           st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  len_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ld_en, cnt_en, last_beat;

  assign ld_en     = (st_q == E_IDLE) && go_i;
  assign beat_o    = (st_q == E_DATA) && rd_dvalid_i && sink_rdy_i;
  assign last_beat = beat_o && (cnt_q == (len_q - 1'b1));
  assign cnt_en    = ld_en || beat_o;
  assign cnt_d     = ld_en ? '0 : (cnt_q + 1'b1);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      E_IDLE:  if (go_i)      st_d = E_REQ;
      E_REQ:   if (bus_gnt_i) st_d = E_CMD;
      E_CMD:                  st_d = E_DATA;
      E_DATA:  if (last_beat) st_d = E_IDLE;
      default:                st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= E_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
    end else if (ld_en) begin
      addr_q <= addr_i;
      len_q  <= nwords_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign bus_req_o   = (st_q != E_IDLE);
  assign rd_cmd_o    = (st_q == E_CMD);
  assign rd_addr_o   = addr_q;
  assign rd_len_o    = len_q;
  assign rd_dready_o = (st_q == E_DATA) && sink_rdy_i;
  assign beat_idx_o  = cnt_q;
  assign done_o      = last_beat;

endmodule

// File: rtl/itx_sched.sv
module itx_sched
  import itx_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 16,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_start_i,
  input  logic [NUM_CTX-1:0] ctx_active_i,
  input  logic               cfg_wr_i,
  input  logic [CTX_W-1:0]   cfg_idx_i,
  input  logic [ADDR_W-1:0]  cfg_ptr_i,
  output logic               bus_req_o,
  input  logic               bus_gnt_i,
  output logic               rd_cmd_o,
  output logic [ADDR_W-1:0]  rd_addr_o,
  output logic [LEN_W-1:0]   rd_len_o,
  input  logic               rd_dvalid_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               rd_dready_o,
  output logic               fifo_push_o,
  output logic [DATA_W-1:0]  fifo_data_o,
  output logic               fifo_mark_o,
  output logic [CTX_W-1:0]   fifo_ctx_o,
  input  logic               fifo_full_i
);

  localparam logic [CTX_W-1:0] LAST_CTX = CTX_W'(NUM_CTX - 1);

  walk_st_t                     st_q, st_d;
  logic [CTX_W-1:0]             idx_q, idx_d;
  logic [LEN_W-1:0]             blen_q;
  logic [ADDR_W-1:0]            paddr_q;
  logic [NUM_CTX-1:0][ADDR_W-1:0] ptr;
  logic                         pend;
  logic                         last_ctx;
  logic [LEN_W:0]               round_sum;
  logic [LEN_W-1:0]             pay_words;
  logic                         eng_go, eng_beat, eng_done, eng_sink_rdy;
  logic [ADDR_W-1:0]            eng_addr;
  logic [LEN_W-1:0]             eng_len, eng_beat_idx;
  logic                         mark_push, pay_push;
  logic                         cap_len_en, cap_addr_en;

  // pointer registers written by software
  itx_ptr_bank #(
    .NUM_CTX (NUM_CTX),
    .ADDR_W  (ADDR_W)
  ) i_ptr_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (cfg_wr_i),
    .idx_i  (cfg_idx_i),
    .data_i (cfg_ptr_i),
    .ptr_o  (ptr)
  );

  // one-deep memory of a cycle start seen during a walk
  itx_start_pend i_start_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (cyc_start_i),
    .busy_i    (st_q != W_IDLE),
    .consume_i (mark_push),
    .pend_o    (pend)
  );

  // single burst engine shared by descriptor and payload phases
  itx_burst_fetch #(
    .ADDR_W (ADDR_W),
    .CNT_W  (LEN_W)
  ) i_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (eng_go),
    .addr_i      (eng_addr),
    .nwords_i    (eng_len),
    .sink_rdy_i  (eng_sink_rdy),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .rd_cmd_o    (rd_cmd_o),
    .rd_addr_o   (rd_addr_o),
    .rd_len_o    (rd_len_o),
    .rd_dvalid_i (rd_dvalid_i),
    .rd_dready_o (rd_dready_o),
    .beat_o      (eng_beat),
    .beat_idx_o  (eng_beat_idx),
    .done_o      (eng_done)
  );

  assign last_ctx     = (idx_q == LAST_CTX);
  assign round_sum    = {1'b0, blen_q} + (LEN_W+1)'(3);
  assign pay_words    = {1'b0, round_sum[LEN_W:2]};
  assign eng_sink_rdy = (st_q == W_PAY) ? !fifo_full_i : 1'b1;
  assign pay_push     = (st_q == W_PAY) && eng_beat;
  assign cap_len_en   = (st_q == W_DESC) && eng_beat && (eng_beat_idx == '0);
  assign cap_addr_en  = (st_q == W_DESC) && eng_beat && (eng_beat_idx != '0);

  // walk sequencing
  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    eng_go    = 1'b0;
    eng_addr  = ptr[idx_q];
    eng_len   = LEN_W'(DESC_WORDS);
    mark_push = 1'b0;
    unique case (st_q)
      W_IDLE: begin
        if (cyc_start_i || pend) begin
          st_d  = W_SCAN;
          idx_d = '0;
        end
      end
      W_SCAN: begin
        if (ctx_active_i[idx_q]) begin
          eng_go = 1'b1;
          st_d   = W_DESC;
        end else if (last_ctx) begin
          st_d = W_MARK;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      W_DESC: begin
        if (eng_done) st_d = W_DEC;
      end
      W_DEC: begin
        if (pay_words != '0) begin
          eng_go   = 1'b1;
          eng_addr = paddr_q;
          eng_len  = pay_words;
          st_d     = W_PAY;
        end else if (last_ctx) begin
          st_d = W_MARK;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = W_SCAN;
        end
      end
      W_PAY: begin
        if (eng_done) begin
          if (last_ctx) begin
            st_d = W_MARK;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = W_SCAN;
          end
        end
      end
      W_MARK: begin
        if (!fifo_full_i) begin
          mark_push = 1'b1;
          idx_d     = '0;
          st_d      = (pend || cyc_start_i) ? W_SCAN : W_IDLE;
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  // descriptor decode registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen_q <= '0;
    end else if (cap_len_en) begin
      blen_q <= rd_data_i[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
    end else if (cap_addr_en) begin
      paddr_q <= rd_data_i[ADDR_W-1:0];
    end
  end

  assign fifo_push_o = pay_push || mark_push;
  assign fifo_mark_o = mark_push;
  assign fifo_data_o = mark_push ? DATA_W'(CYC_MARKER) : rd_data_i;
  assign fifo_ctx_o  = idx_q;

endmodule

// File: rtl/itx_sched_chk.sv
module itx_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req_o,
  input logic bus_gnt_i,
  input logic rd_cmd_o,
  input logic fifo_push_o,
  input logic fifo_full_i
);

  always_comb begin
    if (rst_n == 1'b0) begin
      AST_RESET_QUIET: assert (!bus_req_o && !rd_cmd_o && !fifo_push_o); // R1
    end
  end

  AST_CMD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_o |-> $past(bus_req_o && bus_gnt_i)); // R4

  AST_CMD_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_o |-> bus_req_o); // R4

  AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd_o |=> !rd_cmd_o); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_gnt_i) |=> bus_req_o); // R4

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push_o |-> !fifo_full_i); // R8

endmodule

bind itx_sched itx_sched_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req_o   (bus_req_o),
  .bus_gnt_i   (bus_gnt_i),
  .rd_cmd_o    (rd_cmd_o),
  .fifo_push_o (fifo_push_o),
  .fifo_full_i (fifo_full_i)
);

// File: tb/test_itx_sched.sv
`timescale 1ns/1ps
module test_itx_sched;

  logic        clk;
  logic        rst_n;
  logic        cyc_start_i;
  logic [3:0]  ctx_active_i;
  logic        cfg_wr_i;
  logic [1:0]  cfg_idx_i;
  logic [31:0] cfg_ptr_i;
  logic        bus_req_o;
  logic        bus_gnt_i;
  logic        rd_cmd_o;
  logic [31:0] rd_addr_o;
  logic [15:0] rd_len_o;
  logic        rd_dvalid_i;
  logic [31:0] rd_data_i;
  logic        rd_dready_o;
  logic        fifo_push_o;
  logic [31:0] fifo_data_o;
  logic        fifo_mark_o;
  logic [1:0]  fifo_ctx_o;
  logic        fifo_full_i;

  itx_sched i_itx_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_start_i  (cyc_start_i),
    .ctx_active_i (ctx_active_i),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_idx_i    (cfg_idx_i),
    .cfg_ptr_i    (cfg_ptr_i),
    .bus_req_o    (bus_req_o),
    .bus_gnt_i    (bus_gnt_i),
    .rd_cmd_o     (rd_cmd_o),
    .rd_addr_o    (rd_addr_o),
    .rd_len_o     (rd_len_o),
    .rd_dvalid_i  (rd_dvalid_i),
    .rd_data_i    (rd_data_i),
    .rd_dready_o  (rd_dready_o),
    .fifo_push_o  (fifo_push_o),
    .fifo_data_o  (fifo_data_o),
    .fifo_mark_o  (fifo_mark_o),
    .fifo_ctx_o   (fifo_ctx_o),
    .fifo_full_i  (fifo_full_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 0;

  // host memory model and stimulus knobs
  logic [31:0] mem [logic [31:0]];
  logic [31:0] ptr_m  [4];
  logic [31:0] addr_m [4];
  int          len_m  [4];
  logic [3:0]  act_m;
  int          gnt_dly  = 0;
  bit          gaps     = 0;
  bit          full_mode = 0;

  // expected traffic: {mark, ctx, data} and {addr, len}
  logic [34:0] exp_push [$];
  logic [47:0] exp_cmd  [$];

  // bus responder state
  logic [31:0] baddr;
  int          rem;
  int          gcnt;
  bit          acc;

  function automatic logic [31:0] rdmem(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {a[15:0] ^ 16'hC3A5, a[31:16] + 16'h0101};
  endfunction

  task automatic check(bit ok, string req, logic [47:0] act, logic [47:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  // responder and per-clock comparison against the expected queues
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt_i   = 1'b0;
      rd_dvalid_i = 1'b0;
      rd_data_i   = '0;
      fifo_full_i = 1'b0;
      rem = 0; gcnt = 0; acc = 0; baddr = '0;
    end else begin
      if (acc) begin
        baddr = baddr + 32'd4;
        rem--;
      end
      if (bus_req_o) begin
        if (gcnt == 0) bus_gnt_i = 1'b1;
        else gcnt--;
      end else begin
        bus_gnt_i = 1'b0;
        gcnt = gnt_dly;
      end
      if (rd_cmd_o) begin
        baddr = rd_addr_o;
        rem   = int'(rd_len_o);
        if (exp_cmd.size() == 0) begin
          check(0, "R3 unexpected read command", {rd_addr_o, rd_len_o}, '0);
        end else begin
          logic [47:0] e;
          e = exp_cmd.pop_front();
          // R5 descriptor burst, R6 payload burst, R10 pointer
          check({rd_addr_o, rd_len_o} == e, "R5/R6 read command", {rd_addr_o, rd_len_o}, e);
        end
      end
      rd_dvalid_i = (rem > 0) && (!gaps || ($urandom % 4) != 0);
      rd_data_i   = rdmem(baddr);
      fifo_full_i = full_mode && (($urandom % 3) == 0);
    end
    #1;
    acc = rd_dvalid_i && rd_dready_o;
    if (rst_n && fifo_push_o) begin
      if (fifo_full_i) check(0, "R8 push while full", 48'(fifo_data_o), '0);
      if (exp_push.size() == 0) begin
        check(0, "R7 unexpected push", {13'd0, fifo_mark_o, fifo_ctx_o, fifo_data_o}, '0);
      end else begin
        logic [34:0] e;
        logic [34:0] a;
        e = exp_push.pop_front();
        a = {fifo_mark_o, fifo_ctx_o, fifo_data_o};
        if (e[34]) check(a[34] && a[31:0] == e[31:0], "R7 marker word", 48'(a), 48'(e));
        else       check(a == e, "R2/R6 payload word", 48'(a), 48'(e));
      end
    end
  end

  task automatic expect_walk();
    for (int c = 0; c < 4; c++) begin
      if (act_m[c]) begin
        int words;
        exp_cmd.push_back({ptr_m[c], 16'd2});
        words = (len_m[c] + 3) / 4;
        if (words > 0) begin
          exp_cmd.push_back({addr_m[c], 16'(words)});
          for (int k = 0; k < words; k++)
            exp_push.push_back({1'b0, 2'(c), rdmem(addr_m[c] + 32'(4 * k))});
        end
      end
    end
    exp_push.push_back({1'b1, 2'd3, 32'hFFFF_0000});
  endtask

  task automatic set_ctx(int c, logic [31:0] p, int bytes, logic [31:0] a);
    ptr_m[c]  = p;
    len_m[c]  = bytes;
    addr_m[c] = a;
    mem[p]          = {16'hBEEF, 16'(bytes)};
    mem[p + 32'd4]  = a;
    @(negedge clk);
    cfg_wr_i  = 1'b1;
    cfg_idx_i = 2'(c);
    cfg_ptr_i = p;
    @(negedge clk);
    cfg_wr_i  = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    cyc_start_i = 1'b1;
    @(negedge clk);
    cyc_start_i = 1'b0;
  endtask

  task automatic drain(string req);
    int n;
    n = 0;
    while ((exp_push.size() != 0 || exp_cmd.size() != 0) && n < 4000) begin
      @(negedge clk);
      n++;
    end
    repeat (6) @(negedge clk);
    check(exp_push.size() == 0 && exp_cmd.size() == 0, req,
          48'(exp_push.size()), 48'(exp_cmd.size()));
    #2;
    check(!bus_req_o && !fifo_push_o, {req, " idle after walk"}, 48'(bus_req_o), 0);
  endtask

  task automatic run_walk(logic [3:0] act, string req);
    act_m = act;
    ctx_active_i = act;
    expect_walk();
    pulse();
    drain(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cyc_start_i = 1'b0;
    ctx_active_i = '0;
    cfg_wr_i = 1'b0;
    cfg_idx_i = '0;
    cfg_ptr_i = '0;
    repeat (3) @(negedge clk);
    #2;
    check(!bus_req_o && !rd_cmd_o && !fifo_push_o, "R1 reset outputs",
          {45'd0, bus_req_o, rd_cmd_o, fifo_push_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    ctx_active_i = 4'hF;
    repeat (5) @(negedge clk);
    #2;
    check(!bus_req_o && !fifo_push_o, "R1 idle without start", 48'(bus_req_o), 0);

    set_ctx(0, 32'h1000_0000, 4,  32'h2000_0000);
    set_ctx(1, 32'h1000_0010, 5,  32'h2000_0100);
    set_ctx(2, 32'h1000_0020, 1,  32'h2000_0200);
    set_ctx(3, 32'h1000_0030, 12, 32'h2000_0300);

    run_walk(4'hF, "R2 all contexts");

    gnt_dly = 2; gaps = 1;
    run_walk(4'b1010, "R3 alternating contexts");
    run_walk(4'b0101, "R3 other half");
    run_walk(4'b0000, "R7 marker only");

    set_ctx(1, 32'h1000_0010, 0, 32'h2000_0100);
    run_walk(4'hF, "R6 zero length");

    full_mode = 1;
    set_ctx(1, 32'h1000_0010, 16, 32'h2000_0100);
    run_walk(4'hF, "R8 full stalls");
    full_mode = 0; gnt_dly = 0; gaps = 0;

    // R9: three starts during one walk give exactly one extra walk
    act_m = 4'hF;
    ctx_active_i = 4'hF;
    expect_walk();
    expect_walk();
    pulse();
    repeat (3) @(negedge clk);
    pulse();
    repeat (2) @(negedge clk);
    pulse();
    drain("R9 pending start");

    // R10: pointer rewrite moves the descriptor fetch
    set_ctx(2, 32'h1000_0400, 9, 32'h2000_0800);
    run_walk(4'b0100, "R10 new pointer");

    gnt_dly = 1; gaps = 1; full_mode = 1;
    run_walk(4'b1101, "R2 mixed stress");

    summary();
    $finish;
  end

endmodule